// File: doc/BRIEF.md
# SPI Flash Dummy-Cycle Tracker

This block sits next to an SPI NOR flash controller and snoops the command byte and the data bytes that move to and from the memory. It keeps two shadow copies of the read dummy-cycle setting, one for the flash's non-volatile configuration register and one for its volatile configuration register. From the commands it sees, it decides which copy is in force. The controller reads the count from `dummy_o` and inserts that many dummy clocks before read data.

A shadow copy is updated whenever the controller writes or reads the matching configuration register. Only the first data byte of a transfer counts, and the count is taken from the upper nibble of that byte. Two commands switch the active copy, and the switch happens when the end-of-transfer strobe marks the command as complete. Reset brings back the power-up state, in which both copies hold the default count and the non-volatile copy drives the output.

Top module: `dcyc_tracker`

## Requirements
- R1: After reset, `dummy_o` is 10, the non-volatile copy is the active source, and both shadow copies hold 10.
- R2: `dummy_o` is always in the range 1 to 14.
- R3: A captured byte gives a count equal to its upper nibble (bits 7:4). Nibble values 0 and 15 give 10, and any value above 14 is limited to 14.
- R4: Under command 0xB1, the first byte with `wr_valid_i` high is loaded into the non-volatile copy on that clock edge. If the non-volatile copy is active, `dummy_o` shows the new count in the next cycle, before the transfer ends.
- R5: Under command 0x81, the first byte with `wr_valid_i` high is loaded into the volatile copy. The active source stays as it was until `xfer_done_i` is sampled high with 0x81 on `cmd_i`. From the following cycle the volatile copy drives `dummy_o`.
- R6: When `xfer_done_i` is sampled high with 0x99 on `cmd_i`, the non-volatile copy drives `dummy_o` from the following cycle.
- R7: Under command 0xB5, the first byte with `rd_valid_i` high loads the non-volatile copy. Under 0x85, it loads the volatile copy.
- R8: Only the first qualifying byte between two end-of-transfer strobes is used. Later bytes in the same transfer leave both copies unchanged.
- R9: Any other command code does not change either copy or the active source, even when its bytes carry a valid flag. Data whose valid flag is low is ignored, and so is a valid flag on the data direction that the current command does not use.
- R10: Asserting `rst_ni` in the middle of a transfer at once restores the R1 state, whatever was loaded or selected before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_done_i | input | 1 | One-cycle strobe that marks the end of the current transfer |
| cmd_i | input | 8 | Command byte of the current transfer, held steady for the whole transfer |
| wr_valid_i | input | 1 | Write byte to the flash is valid |
| wr_data_i | input | 8 | Byte being written to the flash |
| rd_valid_i | input | 1 | Read byte from the flash is valid |
| rd_data_i | input | 8 | Byte read from the flash |
| dummy_o | output | 4 | Active dummy-cycle count |

## Verification
The assertions assume that `cmd_i` stays constant from the first data byte through the end-of-transfer strobe, and that the strobe lasts one cycle and never coincides with a data byte. The stimulus keeps to these rules: each transfer is driven by a single task that sets the command first, places the valid bytes with idle gaps between them, and pulses the strobe only after the last byte has been dropped. Between bytes the data lines change while the valid flags are low, so that ignored data also appears on the inputs.

// File: rtl/dcyc_pkg.sv
package dcyc_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_NV_WR,
    OP_NV_RD,
    OP_VOL_WR,
    OP_VOL_RD,
    OP_RST_NV
  } dcyc_op_e;

  typedef enum logic {
    SRC_NV  = 1'b0,
    SRC_VOL = 1'b1
  } dcyc_src_e;

endpackage

// File: rtl/dcyc_cmd_decode.sv
module dcyc_cmd_decode
  import dcyc_pkg::*;
#(
  parameter int                 CMD_W     = 8,
  parameter logic [CMD_W-1:0]   CMD_NV_WR = 8'hB1,
  parameter logic [CMD_W-1:0]   CMD_NV_RD = 8'hB5,
  parameter logic [CMD_W-1:0]   CMD_VL_WR = 8'h81,
  parameter logic [CMD_W-1:0]   CMD_VL_RD = 8'h85,
  parameter logic [CMD_W-1:0]   CMD_RSTNV = 8'h99
) (
  input  logic [CMD_W-1:0] cmd_i,
  output dcyc_op_e         op_o
);

  always_comb begin
    op_o = OP_NONE;
    if      (cmd_i == CMD_NV_WR) op_o = OP_NV_WR;
    else if (cmd_i == CMD_NV_RD) op_o = OP_NV_RD;
    else if (cmd_i == CMD_VL_WR) op_o = OP_VOL_WR;
    else if (cmd_i == CMD_VL_RD) op_o = OP_VOL_RD;
    else if (cmd_i == CMD_RSTNV) op_o = OP_RST_NV;
  end

endmodule

// File: rtl/dcyc_capture.sv
module dcyc_capture
  import dcyc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 4,
  parameter int DEFAULT_DC = 10,
  parameter int MAX_DC     = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_done_i,
  input  dcyc_op_e          op_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              load_nv_o,
  output logic              load_vol_o,
  output logic [CNT_W-1:0]  value_o
);

  localparam logic [CNT_W-1:0] DEF_L  = CNT_W'(DEFAULT_DC);
  localparam logic [CNT_W-1:0] MAX_L  = CNT_W'(MAX_DC);
  localparam int               LSB_W  = DATA_W - CNT_W;

  function automatic logic [CNT_W-1:0] map_nib(input logic [CNT_W-1:0] n);
    if (n == '0 || n == '1) return DEF_L;
    if (n > MAX_L)          return MAX_L;
    return n;
  endfunction

  logic             taken_q;
  logic [CNT_W-1:0] wr_cnt, rd_cnt;
  logic             unused_lsb;

  assign wr_cnt     = map_nib(wr_data_i[DATA_W-1 -: CNT_W]);
  assign rd_cnt     = map_nib(rd_data_i[DATA_W-1 -: CNT_W]);
  assign unused_lsb = ^{wr_data_i[LSB_W-1:0], rd_data_i[LSB_W-1:0]};

  always_comb begin
    load_nv_o  = 1'b0;
    load_vol_o = 1'b0;
    value_o    = wr_cnt;
    if (!taken_q) begin
      unique case (op_i)
        OP_NV_WR:  load_nv_o  = wr_valid_i;
        OP_VOL_WR: load_vol_o = wr_valid_i;
        OP_NV_RD: begin
          load_nv_o = rd_valid_i;
          value_o   = rd_cnt;
        end
        OP_VOL_RD: begin
          load_vol_o = rd_valid_i;
          value_o    = rd_cnt;
        end
        default: ;
      endcase
    end
  end

  // first-byte flag, cleared at every transfer boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      taken_q <= 1'b0;
    else if (xfer_done_i)             taken_q <= 1'b0;
    else if (load_nv_o || load_vol_o) taken_q <= 1'b1;
  end

  assert_single_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_nv_o || load_vol_o) && !xfer_done_i |=> !(load_nv_o || load_vol_o));

  assert_value_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_nv_o || load_vol_o) |-> (value_o != '0 && value_o <= MAX_L));

  assert_one_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_nv_o && load_vol_o));

endmodule

// File: rtl/dcyc_shadow.sv
module dcyc_shadow #(
  parameter int CNT_W     = 4,
  parameter int RESET_VAL = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  output logic [CNT_W-1:0] value_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     value_o <= CNT_W'(RESET_VAL);
    else if (load_i) value_o <= value_i;
  end

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(value_o));

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> value_o == $past(value_i));

endmodule

// File: rtl/dcyc_tracker.sv
module dcyc_tracker
  import dcyc_pkg::*;
#(
  parameter int          CMD_W      = 8,
  parameter int          DATA_W     = 8,
  parameter int          CNT_W      = 4,
  parameter int          DEFAULT_DC = 10,
  parameter int          MAX_DC     = 14,
  parameter logic [7:0]  CMD_NV_WR  = 8'hB1,
  parameter logic [7:0]  CMD_NV_RD  = 8'hB5,
  parameter logic [7:0]  CMD_VL_WR  = 8'h81,
  parameter logic [7:0]  CMD_VL_RD  = 8'h85,
  parameter logic [7:0]  CMD_RSTNV  = 8'h99
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_done_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [CNT_W-1:0]  dummy_o
);

  localparam int               N_COPY = 2;
  localparam logic [CNT_W-1:0] MAX_L  = CNT_W'(MAX_DC);

  dcyc_op_e         op;
  dcyc_src_e        src_q;
  logic             load_nv, load_vol;
  logic [CNT_W-1:0] cap_val;
  logic [N_COPY-1:0]            load_vec;
  logic [N_COPY-1:0][CNT_W-1:0] copy_val;

  dcyc_cmd_decode #(
    .CMD_W     (CMD_W),
    .CMD_NV_WR (CMD_W'(CMD_NV_WR)),
    .CMD_NV_RD (CMD_W'(CMD_NV_RD)),
    .CMD_VL_WR (CMD_W'(CMD_VL_WR)),
    .CMD_VL_RD (CMD_W'(CMD_VL_RD)),
    .CMD_RSTNV (CMD_W'(CMD_RSTNV))
  ) i_decode (
    .cmd_i (cmd_i),
    .op_o  (op)
  );

  dcyc_capture #(
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .DEFAULT_DC (DEFAULT_DC),
    .MAX_DC     (MAX_DC)
  ) i_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xfer_done_i (xfer_done_i),
    .op_i        (op),
    .wr_valid_i  (wr_valid_i),
    .wr_data_i   (wr_data_i),
    .rd_valid_i  (rd_valid_i),
    .rd_data_i   (rd_data_i),
    .load_nv_o   (load_nv),
    .load_vol_o  (load_vol),
    .value_o     (cap_val)
  );

  assign load_vec[SRC_NV]  = load_nv;
  assign load_vec[SRC_VOL] = load_vol;

  for (genvar g = 0; g < N_COPY; g++) begin : g_copy
    dcyc_shadow #(
      .CNT_W     (CNT_W),
      .RESET_VAL (DEFAULT_DC)
    ) i_shadow (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_vec[g]),
      .value_i (cap_val),
      .value_o (copy_val[g])
    );
  end

  // source switches only on command completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_NV;
    end else if (xfer_done_i) begin
      if (op == OP_VOL_WR)      src_q <= SRC_VOL;
      else if (op == OP_RST_NV) src_q <= SRC_NV;
    end
  end

  assign dummy_o = copy_val[src_q];

  assert_out_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_o != '0 && dummy_o <= MAX_L);

  assert_vol_switch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i && cmd_i == CMD_W'(CMD_VL_WR) |=> dummy_o == copy_val[SRC_VOL]);

  assert_nv_switch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i && cmd_i == CMD_W'(CMD_RSTNV) |=> dummy_o == copy_val[SRC_NV]);

  assert_src_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_done_i |=> $stable(src_q));

endmodule

// File: tb/test_dcyc_tracker.sv
module test_dcyc_tracker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done_s = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic       wr_v = 1'b0, rd_v = 1'b0;
  logic [7:0] wr_d = 8'h00, rd_d = 8'h00;
  logic [3:0] dummy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  dcyc_tracker i_dcyc_tracker (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .xfer_done_i (done_s),
    .cmd_i       (cmd),
    .wr_valid_i  (wr_v),
    .wr_data_i   (wr_d),
    .rd_valid_i  (rd_v),
    .rd_data_i   (rd_d),
    .dummy_o     (dummy)
  );

  // monitor: pops expected values and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() != 0) begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        checks++;
        if (int'(dummy) != e) begin
          errors++;
          $display("FAIL %s: dummy_o=%0d expected %0d", t, dummy, e);
        end
      end
    end
  end

  task automatic expect_dc(input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // one transfer: command, nbytes valid bytes with noise gaps, end strobe
  task automatic xfer(input logic [7:0] c, input bit use_rd, input int nbytes,
                      input logic [7:0] b0, input logic [7:0] b1);
    cmd = c;
    tick();
    for (int i = 0; i < nbytes; i++) begin
      if (use_rd) begin rd_v = 1'b1; rd_d = (i == 0) ? b0 : b1; end
      else        begin wr_v = 1'b1; wr_d = (i == 0) ? b0 : b1; end
      tick();
      wr_v = 1'b0; rd_v = 1'b0;
      wr_d = 8'h30; rd_d = 8'hE0;
      tick();
    end
    done_s = 1'b1;
    tick();
    done_s = 1'b0;
    tick();
  endtask

  initial begin
    #5;
    tick();
    tick();
    expect_dc(10, "R1 reset value");
    rst_n = 1'b1;
    tick();
    expect_dc(10, "R1 after release");

    // non-volatile write, visible before end of transfer
    cmd = 8'hB1;
    tick();
    wr_v = 1'b1; wr_d = 8'h70;
    tick();
    wr_v = 1'b0;
    expect_dc(7, "R4 nv write mid-transfer");
    done_s = 1'b1; tick(); done_s = 1'b0; tick();
    expect_dc(7, "R4 nv write after end");

    // volatile write: no switch until strobe
    cmd = 8'h81;
    tick();
    wr_v = 1'b1; wr_d = 8'h5A;
    tick();
    wr_v = 1'b0;
    expect_dc(7, "R5 volatile not active before strobe");
    done_s = 1'b1; tick(); done_s = 1'b0;
    expect_dc(5, "R5 volatile active after strobe");

    xfer(8'hB1, 1'b0, 1, 8'h30, 8'h00);
    expect_dc(5, "R4 nv write hidden while volatile active");
    xfer(8'h99, 1'b0, 0, 8'h00, 8'h00);
    expect_dc(3, "R6 back to non-volatile");

    xfer(8'h85, 1'b1, 1, 8'hC4, 8'h00);
    expect_dc(3, "R7 volatile read while nv active");
    xfer(8'h81, 1'b0, 0, 8'h00, 8'h00);
    expect_dc(12, "R7 volatile read value selected");
    xfer(8'hB5, 1'b1, 1, 8'h2F, 8'h00);
    xfer(8'h99, 1'b0, 0, 8'h00, 8'h00);
    expect_dc(2, "R7 nv read value");

    xfer(8'hB1, 1'b0, 1, 8'hE5, 8'h00);
    expect_dc(14, "R3 nibble 14");
    xfer(8'hB1, 1'b0, 1, 8'hF1, 8'h00);
    expect_dc(10, "R3 nibble 15 default");
    xfer(8'hB1, 1'b0, 1, 8'h40, 8'h00);
    xfer(8'hB1, 1'b0, 1, 8'h0F, 8'h00);
    expect_dc(10, "R3 nibble 0 default");

    xfer(8'hB1, 1'b0, 2, 8'h60, 8'h90);
    expect_dc(6, "R8 second byte ignored");
    xfer(8'hB5, 1'b1, 2, 8'h80, 8'h20);
    expect_dc(8, "R8 second read byte ignored");

    xfer(8'h03, 1'b0, 1, 8'h10, 8'h00);
    xfer(8'hB2, 1'b1, 1, 8'h20, 8'h00);
    xfer(8'h06, 1'b0, 0, 8'h00, 8'h00);
    expect_dc(8, "R9 unrelated commands");
    xfer(8'hB1, 1'b1, 1, 8'h20, 8'h00);
    expect_dc(8, "R9 read flag under write command");
    xfer(8'hB1, 1'b0, 0, 8'h00, 8'h00);
    expect_dc(8, "R9 data with valid low");

    // mid-stream reset while volatile copy is active
    xfer(8'h81, 1'b0, 1, 8'h30, 8'h00);
    expect_dc(3, "R10 volatile active before reset");
    cmd = 8'hB1;
    tick();
    rst_n = 1'b0;
    #1;
    expect_dc(10, "R10 reset mid-stream");
    tick();
    rst_n = 1'b1;
    cmd = 8'h00;
    tick();
    expect_dc(10, "R10 after release");
    xfer(8'h81, 1'b0, 0, 8'h00, 8'h00);
    expect_dc(10, "R1 volatile copy reset to default");

    tick();
    tick();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule